// File: doc/BRIEF.md
# I2C Register and Flow-Control Layer

This block is the software-facing register layer of a byte-oriented I2C peripheral. It sits between a CPU register bus and a separate bit-level I2C engine. It holds a clock control register, which pairs a speed-mode bit with a 7-bit divider, and an 8-bit data register. From these it computes the SCL half-period that the bit engine uses.

Accesses to the data register act as the handshake with the engine. In transmit mode, a software write to the data register issues a one-cycle start pulse. In receive mode, the block captures each byte the engine delivers and then holds SCL low until software reads the data register. The block also detects the general-call address and keeps a flag for it. The flag is cleared by a Stop or when the peripheral is disabled. Disabling the peripheral also clears the divider, drops any pending receive hold and sends an abort to the engine.

Top module: `i2cRegTop`

## Requirements
- R1: After reset, the clock control register and the data register both read 00h. gcFlag, sclHold, txStart and engAbort are all 0.
- R2: A bus write to address 0 loads the clock control register, and a read at address 0 returns it. Bit 7 is the fast bit and bits 6:0 are the divider. While enable is 0 the divider is forced to 0. The fast bit keeps its value across a disable and changes only on writes.
- R3: halfPeriod equals max(divider,1) plus an offset. The offset is FAST_OFS (default 2) when the fast bit is 1 and STD_OFS (default 8) when it is 0.
- R4: A bus write to address 1 loads the data register, and a read at address 1 returns it. txByte always shows the data register.
- R5: A write to address 1 while enable=1 and rxMode=0 makes txStart high for exactly the next cycle. No txStart follows the write when rxMode=1 or enable=0.
- R6: With enable=1 and rxMode=1, an engRxValid pulse while no byte is waiting stores engRxByte in the data register and raises sclHold from the next cycle.
- R7: A read at address 1 while a byte is waiting drops sclHold on the following cycle. The next engRxValid is then accepted.
- R8: An engRxValid pulse while sclHold is high is ignored, and the data register keeps the byte that is waiting.
- R9: gcAck is high in the same cycle as an engAddrValid whose engAddr is 00h (7-bit address 0, write bit 0), but only while gcEnable=1 and enable=1. gcFlag then rises on the next cycle. Any other address, or gcEnable=0, gives neither gcAck nor gcFlag.
- R10: engStop clears gcFlag and sclHold on the next cycle.
- R11: When enable falls, engAbort is high for that single cycle. On the next cycle gcFlag and sclHold are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Peripheral enable |
| gcEnable | input | 1 | General-call recognition enable |
| rxMode | input | 1 | 1 = receive, 0 = transmit |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select: 0 = clock control, 1 = data |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data (combinational) |
| engAddrValid | input | 1 | Engine has received an address byte |
| engAddr | input | 8 | Received address byte including the R/W bit |
| engRxValid | input | 1 | Engine has received a data byte |
| engRxByte | input | 8 | Received data byte |
| engStop | input | 1 | Engine detected a Stop condition |
| halfPeriod | output | 9 | SCL half-period in system clocks |
| fastMode | output | 1 | Fast-mode select for the engine |
| txStart | output | 1 | Start transmitting txByte |
| txByte | output | 8 | Byte to transmit |
| sclHold | output | 1 | Hold SCL low (clock stretch) |
| gcAck | output | 1 | Acknowledge the general-call address |
| gcFlag | output | 1 | General call was seen since the last Stop |
| engAbort | output | 1 | Return the engine to idle |

## Verification
Assertions check the per-cycle rules on every cycle: the divider stays at zero while the peripheral is disabled, and the fast bit is stable without a write. They also check that a transmit-mode data write is followed by txStart, that a data read releases the stretch on the next cycle, and that Stop or disable clears the general-call flag. Other behaviour can only be shown by the bench's scenarios. This covers the arithmetic of the half-period over every divider in both modes, and register readback across all byte values. It also covers the ordering of receive captures against reads, the byte that is dropped while the stretch is held, and the way the general-call address is discriminated from its neighbours.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;
  localparam int DATA_W = 8;
  localparam int DIV_W = 7;
  localparam logic [1:0] ADDR_CC = 2'd0;
  localparam logic [1:0] ADDR_DR = 2'd1;

  typedef struct packed {
    logic wrCc;
    logic wrData;
    logic rdData;
    logic rxCapture;
  } ctrlStrobes_t;
endpackage

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic gcEnable,
  input  logic rxMode,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic [1:0] regAddr,
  input  logic engAddrValid,
  input  logic [DATA_W-1:0] engAddr,
  input  logic engRxValid,
  input  logic engStop,
  output ctrlStrobes_t strobes,
  output logic txStart,
  output logic sclHold,
  output logic gcAck,
  output logic gcFlag,
  output logic engAbort
);
  localparam logic [DATA_W-1:0] GC_ADDR = '0;

  logic byteWaiting;
  logic enPrev;
  logic gcHit;
  logic clearAll;

  assign clearAll = !enable || engStop;
  assign gcHit = engAddrValid && (engAddr == GC_ADDR) && gcEnable && enable;

  always_comb begin
    strobes.wrCc      = regWrEn && (regAddr == ADDR_CC);
    strobes.wrData    = regWrEn && (regAddr == ADDR_DR);
    strobes.rdData    = regRdEn && (regAddr == ADDR_DR);
    strobes.rxCapture = engRxValid && enable && rxMode && !byteWaiting;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteWaiting <= 1'b0;
      gcFlag      <= 1'b0;
      txStart     <= 1'b0;
      enPrev      <= 1'b0;
    end else begin
      enPrev  <= enable;
      txStart <= strobes.wrData && enable && !rxMode;
      if (clearAll) byteWaiting <= 1'b0;
      else if (strobes.rxCapture) byteWaiting <= 1'b1;
      else if (strobes.rdData) byteWaiting <= 1'b0;
      if (clearAll) gcFlag <= 1'b0;
      else if (gcHit) gcFlag <= 1'b1;
    end
  end

  assign sclHold  = byteWaiting;
  assign gcAck    = gcHit;
  assign engAbort = enPrev && !enable;

  p_tx_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_DR && enable && !rxMode) |=> txStart);
  p_hold_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_DR) |=> !sclHold);
  p_gc_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (engStop || !enable) |=> (!gcFlag && !sclHold));
  p_gc_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gcAck && !engStop) |=> gcFlag);
endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cRegPkg::*;
#(
  parameter int FAST_OFS = 2,
  parameter int STD_OFS = 8,
  parameter int HP_W = DIV_W + 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  ctrlStrobes_t strobes,
  input  logic [1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] engRxByte,
  output logic [DATA_W-1:0] regRdData,
  output logic [HP_W-1:0] halfPeriod,
  output logic fastMode,
  output logic [DATA_W-1:0] txByte
);
  logic fastQ;
  logic [DIV_W-1:0] divQ;
  logic [DATA_W-1:0] dataQ;
  logic [HP_W-1:0] divEff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastQ <= 1'b0;
      divQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strobes.wrCc) fastQ <= regWrData[DATA_W-1];
      if (!enable) divQ <= '0;
      else if (strobes.wrCc) divQ <= regWrData[DIV_W-1:0];
      if (strobes.wrData) dataQ <= regWrData;
      else if (strobes.rxCapture) dataQ <= engRxByte;
    end
  end

  always_comb begin
    divEff = (divQ == '0) ? HP_W'(1) : HP_W'(divQ);
    halfPeriod = divEff + (fastQ ? HP_W'(FAST_OFS) : HP_W'(STD_OFS));
    case (regAddr)
      ADDR_CC: regRdData = {fastQ, divQ};
      ADDR_DR: regRdData = dataQ;
      default: regRdData = '0;
    endcase
  end

  assign fastMode = fastQ;
  assign txByte = dataQ;

  p_div_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (divQ == '0));
  p_fast_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrCc |=> $stable(fastQ));
  p_dr_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrData |=> (dataQ == $past(regWrData)));
  p_hp_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    halfPeriod > HP_W'(0));
endmodule

// File: rtl/i2cRegTop.sv
module i2cRegTop
  import i2cRegPkg::*;
#(
  parameter int FAST_OFS = 2,
  parameter int STD_OFS = 8,
  localparam int HP_W = DIV_W + 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic gcEnable,
  input  logic rxMode,
  input  logic regWrEn,
  input  logic regRdEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic engAddrValid,
  input  logic [7:0] engAddr,
  input  logic engRxValid,
  input  logic [7:0] engRxByte,
  input  logic engStop,
  output logic [HP_W-1:0] halfPeriod,
  output logic fastMode,
  output logic txStart,
  output logic [7:0] txByte,
  output logic sclHold,
  output logic gcAck,
  output logic gcFlag,
  output logic engAbort
);
  ctrlStrobes_t strobes;

  i2cRegCtrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .gcEnable(gcEnable),
    .rxMode(rxMode), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .engAddrValid(engAddrValid), .engAddr(engAddr), .engRxValid(engRxValid),
    .engStop(engStop), .strobes(strobes), .txStart(txStart), .sclHold(sclHold),
    .gcAck(gcAck), .gcFlag(gcFlag), .engAbort(engAbort)
  );

  i2cRegData #(.FAST_OFS(FAST_OFS), .STD_OFS(STD_OFS), .HP_W(HP_W)) uData (
    .clk(clk), .rstN(rstN), .enable(enable), .strobes(strobes),
    .regAddr(regAddr), .regWrData(regWrData), .engRxByte(engRxByte),
    .regRdData(regRdData), .halfPeriod(halfPeriod), .fastMode(fastMode),
    .txByte(txByte)
  );
endmodule

// File: tb/sim_i2cRegTop.sv
`timescale 1ns/1ps
module sim_i2cRegTop;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, gcEnable = 1'b0, rxMode = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic engAddrValid = 1'b0, engRxValid = 1'b0, engStop = 1'b0;
  logic [7:0] engAddr = '0, engRxByte = '0;
  logic [8:0] halfPeriod;
  logic fastMode, txStart, sclHold, gcAck, gcFlag, engAbort;
  logic [7:0] txByte;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2cRegTop u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  initial begin
    logic [7:0] rd;
    int expHp;
    @(negedge clk);
    tick(); tick();
    rstN = 1'b1;
    #1;
    readReg(2'd0, rd); chk(rd == 8'h00, "R1 cc", rd, 0);
    readReg(2'd1, rd); chk(rd == 8'h00, "R1 dr", rd, 0);
    chk(!gcFlag && !sclHold && !txStart && !engAbort, "R1 flags",
        {gcFlag, sclHold, txStart, engAbort}, 0);

    enable = 1'b1;
    tick();
    for (int f = 0; f < 2; f++) begin
      for (int dv = 0; dv < 128; dv++) begin
        busWrite(2'd0, 8'((f << 7) | dv));
        readReg(2'd0, rd);
        chk(rd == 8'((f << 7) | dv), "R2 readback", rd, (f << 7) | dv);
        expHp = ((dv == 0) ? 1 : dv) + ((f == 1) ? 2 : 8);
        chk(int'(halfPeriod) == expHp, "R3 halfPeriod", halfPeriod, expHp);
      end
    end

    busWrite(2'd0, 8'h85);
    enable = 1'b0;
    tick();
    readReg(2'd0, rd); chk(rd == 8'h80, "R2 disable keeps fast", rd, 8'h80);
    busWrite(2'd0, 8'h3F);
    readReg(2'd0, rd); chk(rd == 8'h00, "R2 disabled write", rd, 0);
    busWrite(2'd0, 8'hFF);
    readReg(2'd0, rd); chk(rd == 8'h80, "R2 fast writable", rd, 8'h80);
    enable = 1'b1;
    tick();

    rxMode = 1'b0;
    for (int v = 0; v < 256; v++) begin
      busWrite(2'd1, 8'(v));
      chk(txStart == 1'b1, "R5 txStart", txStart, 1);
      chk(int'(txByte) == v, "R4 txByte", txByte, v);
      readReg(2'd1, rd); chk(int'(rd) == v, "R4 readback", rd, v);
      tick();
      chk(txStart == 1'b0, "R5 single pulse", txStart, 0);
    end
    rxMode = 1'b1;
    busWrite(2'd1, 8'h11);
    chk(txStart == 1'b0, "R5 no start rx", txStart, 0);
    rxMode = 1'b0; enable = 1'b0;
    busWrite(2'd1, 8'h22);
    chk(txStart == 1'b0, "R5 no start disabled", txStart, 0);
    enable = 1'b1; rxMode = 1'b1;
    tick();

    engRxByte = 8'hA5; engRxValid = 1'b1; tick(); engRxValid = 1'b0;
    chk(sclHold == 1'b1, "R6 hold", sclHold, 1);
    readReg(2'd1, rd); chk(rd == 8'hA5, "R6 capture", rd, 8'hA5);
    engRxByte = 8'h3C; engRxValid = 1'b1; tick(); engRxValid = 1'b0;
    readReg(2'd1, rd); chk(rd == 8'hA5, "R8 ignored", rd, 8'hA5);
    chk(sclHold == 1'b1, "R8 still held", sclHold, 1);
    regAddr = 2'd1; regRdEn = 1'b1;
    #1 chk(sclHold == 1'b1, "R7 held during read", sclHold, 1);
    tick(); regRdEn = 1'b0;
    chk(sclHold == 1'b0, "R7 released", sclHold, 0);
    engRxValid = 1'b1; tick(); engRxValid = 1'b0;
    readReg(2'd1, rd); chk(rd == 8'h3C, "R7 next byte", rd, 8'h3C);
    engStop = 1'b1; tick(); engStop = 1'b0;
    chk(sclHold == 1'b0, "R10 stop releases hold", sclHold, 0);

    gcEnable = 1'b1; engAddr = 8'h00; engAddrValid = 1'b1;
    #1 chk(gcAck == 1'b1, "R9 gcAck", gcAck, 1);
    tick(); engAddrValid = 1'b0;
    chk(gcFlag == 1'b1, "R9 gcFlag", gcFlag, 1);
    engStop = 1'b1; tick(); engStop = 1'b0;
    chk(gcFlag == 1'b0, "R10 stop clears", gcFlag, 0);
    gcEnable = 1'b0; engAddrValid = 1'b1;
    #1 chk(gcAck == 1'b0, "R9 gc disabled", gcAck, 0);
    tick(); chk(gcFlag == 1'b0, "R9 no flag disabled", gcFlag, 0);
    gcEnable = 1'b1; engAddr = 8'h01;
    #1 chk(gcAck == 1'b0, "R9 read bit", gcAck, 0);
    engAddr = 8'h02;
    #1 chk(gcAck == 1'b0, "R9 nonzero addr", gcAck, 0);
    tick(); engAddrValid = 1'b0;
    chk(gcFlag == 1'b0, "R9 no flag other addr", gcFlag, 0);

    engAddr = 8'h00; engAddrValid = 1'b1; tick(); engAddrValid = 1'b0;
    engRxByte = 8'h5A; engRxValid = 1'b1; tick(); engRxValid = 1'b0;
    chk(gcFlag && sclHold, "R11 setup", {gcFlag, sclHold}, 3);
    enable = 1'b0;
    #1 chk(engAbort == 1'b1, "R11 abort", engAbort, 1);
    tick();
    chk(engAbort == 1'b0, "R11 abort one cycle", engAbort, 0);
    chk(!gcFlag && !sclHold, "R11 cleared", {gcFlag, sclHold}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule